// File: doc/BRIEF.md
# Coprocessor Restore Register Responder

This block is the coprocessor-side logic behind the register window that a host uses to reload a saved coprocessor context. The host writes a format word to the restore register. The block immediately signals the coprocessor core to drop whatever it is doing. It then checks the word against a parameter list of supported state frames. A supported word is echoed back in the restore register. An unsupported word is replaced there by a fixed invalid-format code.

The host reads the restore register to learn the outcome. When the echo matches, the host sends the frame body through the operand register, one 32-bit word per write. The block forwards each word downstream as a context stream. It marks the final word and raises a restore-complete flag. Operand writes that have no restore to feed are dropped and flagged. A control-register abort cancels a restore that is in progress.

Top module: `ctx_restore_resp`

## Requirements
- R1: Every write to the restore register (select code 0) raises `abort_op` for exactly one cycle, in the cycle after the write is sampled. `abort_op` is low in every other cycle.
- R2: A format word is supported only if its code (bits 31:24) and its byte length (bits 23:16) both match one configured pair. The defaults are code 0x41 with 8 bytes, code 0x42 with 12 bytes, and code 0x60 with 0 bytes.
- R3: After a supported word is written, the restore register reads back the whole written word, low bits included, from the next cycle onward.
- R4: After an unsupported word is written, the restore register reads 0x0100_0000 and no operand data is accepted.
- R5: Each operand-register write (select code 1) made while frame bytes remain is handled as follows:
  - Its data appears on `ctx_data` with `ctx_valid` high for one cycle, in the next cycle.
  - The remaining byte count drops by 4.
- R6: The final frame word is handled as follows:
  - It carries `ctx_last`, and `restore_done` rises in the same cycle.
  - A supported 0-byte format raises `restore_done` directly after its write.
  - `restore_done` is cleared by a new restore write or by a control abort.
- R7: An operand write that arrives with no bytes remaining is handled as follows:
  - It produces no stream word.
  - It sets `proto_err`, which stays high until reset.
- R8: A control-register write (select code 2) with bit 0 set cancels any restore in progress, so later operand writes are stray. A control write with bit 0 clear has no effect.
- R9: `reg_rdata` shows the restore register combinationally while `reg_sel` is 0, and reads zero for every other select. A write with select code 3 has no effect.
- R10: After reset, the following outputs are all zero: the restore register, `abort_op`, `ctx_valid`, `ctx_last`, `restore_done` and `proto_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 restore, 1 operand, 2 control, 3 unused |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (restore register when selected, else zero) |
| abort_op | output | 1 | One-cycle request to stop the current coprocessor operation |
| ctx_valid | output | 1 | Context stream word valid |
| ctx_data | output | 32 | Context stream word |
| ctx_last | output | 1 | Marks the final word of the frame |
| restore_done | output | 1 | Frame fully received |
| proto_err | output | 1 | Sticky flag for a stray operand write |

## Verification
The following results are all due exactly one rising edge after the write is sampled:
- the abort pulse;
- the restore read-back;
- the stream word and its last flag;
- restore-complete;
- the error flag.

`reg_rdata` follows `reg_sel` within the same cycle. A behavioural model in the bench applies each sampled write at the rising edge. The outputs are compared with the model 3 ns after every rising edge, so each result is checked in the cycle it becomes due. Directed checks, taken at that same point, cover the following:
- the invalid code;
- length mismatches;
- zero-length frames;
- control aborts;
- stray operands.

// File: rtl/ctxr_pkg.sv
// Shared constants for the coprocessor restore responder.
// Assumes a 32-bit register window with code and length fields at fixed bits.
package ctxr_pkg;
    typedef enum logic [1:0] {
        SEL_RESTORE = 2'd0,
        SEL_OPERAND = 2'd1,
        SEL_CONTROL = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;

    localparam int WORD_W    = 32;
    localparam int CODE_LSB  = 24;
    localparam int CODE_W    = 8;
    localparam int LEN_LSB   = 16;
    localparam int LEN_W     = 8;
    localparam int ABORT_BIT = 0;
    localparam int BEAT_BYTES = WORD_W / 8;
    localparam logic [WORD_W-1:0] INVALID_WORD = 32'h0100_0000;
endpackage

// File: rtl/ctxr_fmt_match.sv
// Decides whether a format word names a supported state frame.
// Assumes NUM_FMT (code, length) pairs packed 8 bits each, entry 0 lowest.
module ctxr_fmt_match
    import ctxr_pkg::*;
#(
    parameter int NUM_FMT = 3,
    parameter logic [NUM_FMT*CODE_W-1:0] CODES = {8'h60, 8'h42, 8'h41},
    parameter logic [NUM_FMT*LEN_W-1:0]  LENS  = {8'h00, 8'h0C, 8'h08}
) (
    input  logic [WORD_W-1:0] word,
    output logic              hit
);
    logic [NUM_FMT-1:0] hit_v;
    logic [CODE_W-1:0]  code_f;
    logic [LEN_W-1:0]   len_f;

    assign code_f = word[CODE_LSB +: CODE_W];
    assign len_f  = word[LEN_LSB +: LEN_W];

    // One comparator per configured pair: both fields must match.
    for (genvar i = 0; i < NUM_FMT; i++) begin : g_pair
        assign hit_v[i] = (code_f == CODES[i*CODE_W +: CODE_W]) &&
                          (len_f  == LENS[i*LEN_W +: LEN_W]);
    end

    assign hit = |hit_v;
endmodule

// File: rtl/ctxr_seq.sv
// Restore sequencer: holds the restore register, remaining byte count,
// completion and error flags, and issues the abort pulse.
// Assumes configured frame lengths are multiples of the 4-byte beat.
module ctxr_seq
    import ctxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              fmt_hit,
    output logic [WORD_W-1:0] restore_q,
    output logic              abort_op,
    output logic              fire,
    output logic              fire_last,
    output logic              restore_done,
    output logic              proto_err
);
    logic [LEN_W-1:0] remaining;
    logic             restore_wr;
    logic             operand_wr;
    logic             ctrl_abort;
    logic             active;
    logic [LEN_W-1:0] new_len;

    // Decode the write strobe into per-register events.
    always_comb begin
        restore_wr = wr && (sel == SEL_RESTORE);
        operand_wr = wr && (sel == SEL_OPERAND);
        ctrl_abort = wr && (sel == SEL_CONTROL) && wdata[ABORT_BIT];
        new_len    = wdata[LEN_LSB +: LEN_W];
        active     = (remaining != '0);
        fire       = operand_wr && active;
        fire_last  = fire && (remaining <= LEN_W'(BEAT_BYTES));
    end

    // One-cycle abort request after each restore-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) abort_op <= 1'b0;
        else        abort_op <= restore_wr;
    end

    // Restore register: echo a supported word, else the invalid code.
    always_ff @(posedge clk) begin
        if (!rst_n)          restore_q <= '0;
        else if (restore_wr) restore_q <= fmt_hit ? wdata : INVALID_WORD;
    end

    // Remaining frame bytes still to be accepted through the operand register.
    always_ff @(posedge clk) begin
        if (!rst_n)          remaining <= '0;
        else if (restore_wr) remaining <= fmt_hit ? new_len : '0;
        else if (ctrl_abort) remaining <= '0;
        else if (fire)       remaining <= fire_last ? '0 : remaining - LEN_W'(BEAT_BYTES);
    end

    // Completion flag: set by the last beat or a zero-length frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          restore_done <= 1'b0;
        else if (restore_wr) restore_done <= fmt_hit && (new_len == '0);
        else if (ctrl_abort) restore_done <= 1'b0;
        else if (fire_last)  restore_done <= 1'b1;
    end

    // Sticky error for operand writes with nothing to feed.
    always_ff @(posedge clk) begin
        if (!rst_n)                     proto_err <= 1'b0;
        else if (operand_wr && !active) proto_err <= 1'b1;
    end
endmodule

// File: rtl/ctxr_stream_out.sv
// Registers accepted operand words onto the downstream context stream.
// Assumes the consumer takes every word; no back-pressure is provided.
module ctxr_stream_out
    import ctxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              fire_last,
    input  logic [WORD_W-1:0] wdata,
    output logic              ctx_valid,
    output logic              ctx_last,
    output logic [WORD_W-1:0] ctx_data
);
    // Valid and last flags, one cycle per accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_valid <= 1'b0;
            ctx_last  <= 1'b0;
        end else begin
            ctx_valid <= fire;
            ctx_last  <= fire_last;
        end
    end

    // Data register, loaded only on an accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctx_data <= '0;
        else if (fire) ctx_data <= wdata;
    end
endmodule

// File: rtl/ctx_restore_resp.sv
// Top of the coprocessor restore responder: register window, format check,
// restore sequencing and context stream. Reads are combinational.
module ctx_restore_resp
    import ctxr_pkg::*;
#(
    parameter int NUM_FMT = 3,
    parameter logic [NUM_FMT*8-1:0] FMT_CODES = {8'h60, 8'h42, 8'h41},
    parameter logic [NUM_FMT*8-1:0] FMT_LENS  = {8'h00, 8'h0C, 8'h08}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        abort_op,
    output logic        ctx_valid,
    output logic [31:0] ctx_data,
    output logic        ctx_last,
    output logic        restore_done,
    output logic        proto_err
);
    reg_sel_e          sel;
    logic              fmt_hit;
    logic              fire;
    logic              fire_last;
    logic [WORD_W-1:0] restore_q;

    assign sel = reg_sel_e'(reg_sel);

    ctxr_fmt_match #(
        .NUM_FMT (NUM_FMT),
        .CODES   (FMT_CODES),
        .LENS    (FMT_LENS)
    ) u_match (
        .word (reg_wdata),
        .hit  (fmt_hit)
    );

    ctxr_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (reg_wr),
        .sel          (sel),
        .wdata        (reg_wdata),
        .fmt_hit      (fmt_hit),
        .restore_q    (restore_q),
        .abort_op     (abort_op),
        .fire         (fire),
        .fire_last    (fire_last),
        .restore_done (restore_done),
        .proto_err    (proto_err)
    );

    ctxr_stream_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .fire_last (fire_last),
        .wdata     (reg_wdata),
        .ctx_valid (ctx_valid),
        .ctx_last  (ctx_last),
        .ctx_data  (ctx_data)
    );

    // Read mux: only the restore register is readable.
    always_comb begin
        reg_rdata = (sel == SEL_RESTORE) ? restore_q : '0;
    end
endmodule

// File: rtl/ctxr_checker.sv
// Protocol checker for ctx_restore_resp, attached by bind below.
module ctxr_checker
    import ctxr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  reg_sel,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] restore_q,
    input logic        abort_op,
    input logic        ctx_valid,
    input logic        ctx_last,
    input logic        restore_done,
    input logic        proto_err
);
    a_r1_abort_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |=> abort_op);
    a_r1_abort_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel == 2'd0) |=> !abort_op);
    a_r3_readback_echo_or_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |=> (restore_q == $past(reg_wdata) || restore_q == INVALID_WORD));
    a_r5_stream_from_operand: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_valid |-> $past(reg_wr && reg_sel == 2'd1));
    a_r6_last_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_last |-> (ctx_valid && restore_done));
    a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
    a_r8_control_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd2 && reg_wdata[0]) |=> (!restore_done && !ctx_valid));
endmodule

bind ctx_restore_resp ctxr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_sel      (reg_sel),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .restore_q    (restore_q),
    .abort_op     (abort_op),
    .ctx_valid    (ctx_valid),
    .ctx_last     (ctx_last),
    .restore_done (restore_done),
    .proto_err    (proto_err)
);

// File: tb/ctx_restore_resp_tb_top.sv
// Bench: behavioural model updated at each rising edge, compared 3 ns later.
module ctx_restore_resp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        abort_op, ctx_valid, ctx_last, restore_done, proto_err;
    logic [31:0] ctx_data;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // model state
    logic [31:0] m_restore = '0;
    int          m_rem = 0;
    bit          m_done = 0, m_err = 0, m_abort = 0, m_cv = 0, m_cl = 0;
    logic [31:0] m_cd = '0;

    always #5 clk = ~clk;

    ctx_restore_resp dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .abort_op(abort_op),
        .ctx_valid(ctx_valid), .ctx_data(ctx_data), .ctx_last(ctx_last),
        .restore_done(restore_done), .proto_err(proto_err)
    );

    function automatic bit supported(logic [31:0] w);
        return (w[31:24] == 8'h41 && w[23:16] == 8'd8) ||
               (w[31:24] == 8'h42 && w[23:16] == 8'd12) ||
               (w[31:24] == 8'h60 && w[23:16] == 8'd0);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // Reference model: applies the write sampled at this edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_restore = '0; m_rem = 0; m_done = 0; m_err = 0;
            m_abort = 0; m_cv = 0; m_cl = 0; m_cd = '0;
        end else begin
            m_abort = 0; m_cv = 0; m_cl = 0;
            if (reg_wr) begin
                case (reg_sel)
                    2'd0: begin
                        m_abort = 1;
                        if (supported(reg_wdata)) begin
                            m_restore = reg_wdata;
                            m_rem = int'(reg_wdata[23:16]);
                            m_done = (m_rem == 0);
                        end else begin
                            m_restore = 32'h0100_0000; m_rem = 0; m_done = 0;
                        end
                    end
                    2'd1: begin
                        if (m_rem > 0) begin
                            m_cv = 1; m_cd = reg_wdata; m_rem -= 4;
                            if (m_rem <= 0) begin m_rem = 0; m_cl = 1; m_done = 1; end
                        end else m_err = 1;
                    end
                    2'd2: if (reg_wdata[0]) begin m_rem = 0; m_done = 0; end
                    default: ;
                endcase
            end
        end
    end

    // Every-cycle comparison, away from the edge.
    always @(posedge clk) begin
        #3;
        if (!finished) begin
            check("R1 abort_op", 32'(abort_op), 32'(m_abort));
            check("R3 reg_rdata", reg_rdata, (reg_sel == 2'd0) ? m_restore : 32'h0);
            check("R5 ctx_valid", 32'(ctx_valid), 32'(m_cv));
            if (m_cv) check("R5 ctx_data", ctx_data, m_cd);
            check("R6 ctx_last", 32'(ctx_last), 32'(m_cl));
            check("R6 restore_done", 32'(restore_done), 32'(m_done));
            check("R7 proto_err", 32'(proto_err), 32'(m_err));
        end
    end

    task automatic wr(logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #3;
        reg_wr = 1'b0;
    endtask

    task automatic idle_sel(logic [1:0] s);
        @(negedge clk);
        reg_sel = s;
        @(posedge clk); #3;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        reg_sel = 2'd0;
        @(posedge clk); #3;
    endtask

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        do_reset();
        // R10: reset state
        check("R10 restore", reg_rdata, 32'h0);
        check("R10 flags", {28'h0, abort_op, ctx_valid, restore_done, proto_err}, 32'h0);

        // R2/R3: supported 0x41 with 8 bytes, low bits echoed
        wr(2'd0, 32'h4108_1234);
        check("R3 echo", reg_rdata, 32'h4108_1234);
        check("R1 pulse", 32'(abort_op), 32'h1);
        wr(2'd1, 32'hAAAA_0001);
        check("R5 first beat", ctx_data, 32'hAAAA_0001);
        wr(2'd1, 32'hAAAA_0002);
        check("R6 last beat", {30'h0, ctx_last, restore_done}, 32'h3);
        idle_sel(2'd0);
        check("R1 single pulse", 32'(abort_op), 32'h0);
        check("R6 done held", 32'(restore_done), 32'h1);

        // R7: extra operand after completion
        wr(2'd1, 32'hDEAD_0000);
        check("R7 stray dropped", {30'h0, ctx_valid, proto_err}, 32'h1);
        do_reset();
        check("R10 err cleared", 32'(proto_err), 32'h0);

        // R2/R4: right code, wrong length
        wr(2'd0, 32'h410C_0000);
        check("R4 invalid word", reg_rdata, 32'h0100_0000);
        check("R1 pulse invalid", 32'(abort_op), 32'h1);
        wr(2'd1, 32'h1111_1111);
        check("R4 no data accepted", 32'(ctx_valid), 32'h0);
        do_reset();

        // R2: unknown code
        wr(2'd0, 32'h7708_0000);
        check("R2 unknown code", reg_rdata, 32'h0100_0000);

        // R6: zero-length frame
        wr(2'd0, 32'h6000_00FF);
        check("R6 zero-length done", 32'(restore_done), 32'h1);
        check("R2 zero-length echo", reg_rdata, 32'h6000_00FF);

        // R8: control bit 0 clear has no effect, bit 0 set cancels
        wr(2'd0, 32'h420C_0000);
        check("R6 done cleared by restore", 32'(restore_done), 32'h0);
        wr(2'd1, 32'h2222_0001);
        wr(2'd2, 32'h0000_0002);
        wr(2'd1, 32'h2222_0002);
        check("R8 no-op control", {31'h0, ctx_valid}, 32'h1);
        wr(2'd2, 32'h0000_0001);
        check("R8 cancel", {30'h0, ctx_valid, restore_done}, 32'h0);
        wr(2'd1, 32'h2222_0003);
        check("R8 operand after cancel", {30'h0, ctx_valid, proto_err}, 32'h1);
        do_reset();

        // R1/R5: restart mid-restore
        wr(2'd0, 32'h4108_0000);
        wr(2'd1, 32'h3333_0001);
        wr(2'd0, 32'h420C_0000);
        check("R1 restart pulse", 32'(abort_op), 32'h1);
        for (int i = 0; i < 3; i++) wr(2'd1, 32'h4444_0000 + 32'(i));
        check("R6 three-beat last", {30'h0, ctx_last, restore_done}, 32'h3);
        check("R5 last data", ctx_data, 32'h4444_0002);

        // R9: spare select write ignored, reads by select
        wr(2'd3, 32'h4108_0000);
        check("R9 spare write", 32'(abort_op), 32'h0);
        idle_sel(2'd1);
        check("R9 operand reads zero", reg_rdata, 32'h0);
        idle_sel(2'd2);
        check("R9 control reads zero", reg_rdata, 32'h0);
        idle_sel(2'd0);
        check("R9 restore reads", reg_rdata, 32'h420C_0000);

        repeat (2) @(posedge clk);
        #4;
        summary();
    end
endmodule